// File: doc/BRIEF.md
# Timer Capture/Compare Channel Register

This block is one channel of a general-purpose timer. It holds a 16-bit value that means one of two things, depending on a mode input. In output mode, software writes a value into a visible holding register. A second, active register holds the value that is compared against the running timer count. A preload-enable bit decides when the active copy picks up the written value. With preload off, the active copy follows the holding register on every clock. With preload on, the active copy changes only on an update strobe.

In input mode, the same visible register becomes a capture latch. A capture strobe stores the present count in it, and software writes no longer reach it. The stored value survives mode changes in either direction. Reads always show the visible register. The compare output is registered and rises one clock after the count equals the active value.

Top module: `capcmp_chan`

## Requirements
- R1: After synchronous reset, `rd_data` and `cmp_out` are 0 and the active compare value is 0, so a count of 0 in output mode produces a match.
- R2: In output mode (`mode_sel`=0), a write stores `wr_data` in the visible register, and it is seen on `rd_data` after that clock edge.
- R3: With `preload_en`=0 in output mode, the active value equals the visible register's new value after every clock edge, including the edge that takes a write.
- R4: With `preload_en`=1 in output mode and no update strobe, the active value does not change, even when the visible register is written.
- R5: With `preload_en`=1 in output mode, an `update_evt` strobe copies the visible register into the active value.
- R6: When a write and `update_evt` arrive on the same edge with preload enabled, the active value takes the visible register's old content, and the visible register takes the new write.
- R7: `cmp_out` is 1 in the cycle after an edge at which the mode was output and `count` equalled the active value (not the visible value). Otherwise it is 0. This includes the all-ones value 0xFFFF.
- R8: In input mode (`mode_sel`=1), a `capture_evt` strobe stores `count` in the visible register.
- R9: In input mode, writes leave the visible register unchanged. When a write and a capture arrive on the same edge, the capture value is stored.
- R10: Changing `mode_sel` clears neither the visible register nor the active value.
- R11: In input mode, `cmp_out` stays 0 whatever the count is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | 0 = output compare, 1 = input capture |
| preload_en | input | 1 | 1 = active value loads only on update strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | W | Register write value |
| rd_data | output | W | Visible register content |
| update_evt | input | 1 | Update-event strobe |
| capture_evt | input | 1 | Capture strobe |
| count | input | W | Timer counter value |
| cmp_out | output | 1 | Registered compare-match output |

## Verification
The compare path is driven with the count set to the active value and, in separate steps, to the freshly written preload value. This shows whether the comparator reads the active copy or the visible one. Preload on and preload off are run with the same writes, so a wrong transfer timing shows up as a match one step early or late. A write coinciding with an update, and a write coinciding with a capture, isolate the two same-edge orderings. Round trips between the modes, with a count that would otherwise match, confirm that the stored values survive and that the output is gated.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  typedef enum logic {
    CH_OUTPUT = 1'b0,
    CH_INPUT  = 1'b1
  } ch_mode_e;
endpackage

// File: rtl/capcmp_store.sv
module capcmp_store
  import capcmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  ch_mode_e     mode,
  input  logic         pre_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         upd,
  input  logic         cap,
  input  logic [W-1:0] cnt,
  output logic [W-1:0] vis_q,
  output logic [W-1:0] act_q
);
  logic [W-1:0] vis_nx;
  logic [W-1:0] act_nx;

  // visible register: write port in output mode, capture latch in input mode
  always_comb begin
    vis_nx = vis_q;
    if (mode == CH_INPUT) begin
      if (cap) vis_nx = cnt;
    end else if (wr_en) begin
      vis_nx = wr_data;
    end
  end

  // active copy: tracks the visible value, or waits for an update strobe
  always_comb begin
    act_nx = act_q;
    if (mode == CH_OUTPUT) begin
      if (!pre_en)  act_nx = vis_nx;
      else if (upd) act_nx = vis_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vis_q <= '0;
      act_q <= '0;
    end else begin
      vis_q <= vis_nx;
      act_q <= act_nx;
    end
  end

  // R3
  direct_load_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == CH_OUTPUT && !pre_en && wr_en) |=> (act_q == $past(wr_data)));

  // R4
  preload_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == CH_OUTPUT && pre_en && !upd) |=> $stable(act_q));

  // R8
  capture_load_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == CH_INPUT && cap) |=> (vis_q == $past(cnt)));

  // R9
  input_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == CH_INPUT && !cap) |=> $stable(vis_q));
endmodule

// File: rtl/capcmp_match.sv
module capcmp_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] act,
  output logic         hit_q
);
  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= enable && (cnt == act);
  end

  // R7
  hit_cause_chk: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> ($past(cnt) == $past(act)));

  // R11
  hit_gate_chk: assert property (@(posedge clk) disable iff (rst)
    hit_q |-> $past(enable));
endmodule

// File: rtl/capcmp_chan.sv
module capcmp_chan
  import capcmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_sel,
  input  logic         preload_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         update_evt,
  input  logic         capture_evt,
  input  logic [W-1:0] count,
  output logic         cmp_out
);
  ch_mode_e     mode;
  logic [W-1:0] vis;
  logic [W-1:0] act;

  assign mode = ch_mode_e'(mode_sel);

  capcmp_store #(.W(W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .pre_en  (preload_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .upd     (update_evt),
    .cap     (capture_evt),
    .cnt     (count),
    .vis_q   (vis),
    .act_q   (act)
  );

  capcmp_match #(.W(W)) u_match (
    .clk    (clk),
    .rst    (rst),
    .enable (mode == CH_OUTPUT),
    .cnt    (count),
    .act    (act),
    .hit_q  (cmp_out)
  );

  assign rd_data = vis;

  // R10
  mode_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_sel) != mode_sel && !$past(wr_en) && !$past(capture_evt)
     && !$past(update_evt) && $past(preload_en)) |-> $stable(rd_data));
endmodule

// File: tb/test_capcmp_chan.sv
module test_capcmp_chan;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mode_sel = 1'b0;
  logic         preload_en = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         update_evt = 1'b0;
  logic         capture_evt = 1'b0;
  logic [W-1:0] count = '0;
  logic         cmp_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0] rd;
    logic         cmp;
    string        tag;
  } exp_t;
  exp_t sb[$];

  logic [W-1:0] m_vis = '0;
  logic [W-1:0] m_act = '0;

  always #10 clk = ~clk;

  capcmp_chan #(.W(W)) i_capcmp_chan (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .preload_en(preload_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .update_evt(update_evt), .capture_evt(capture_evt),
    .count(count), .cmp_out(cmp_out)
  );

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic step(input bit md, input bit pe, input bit we, input logic [W-1:0] wd,
                      input bit up, input bit cp, input logic [W-1:0] cn, input string tag);
    exp_t e;
    logic [W-1:0] nvis;
    logic [W-1:0] nact;
    @(negedge clk);
    mode_sel = md; preload_en = pe; wr_en = we; wr_data = wd;
    update_evt = up; capture_evt = cp; count = cn;
    e.cmp = (!md) && (cn == m_act);
    nvis = m_vis;
    nact = m_act;
    if (md) begin
      if (cp) nvis = cn;
    end else begin
      if (we) nvis = wd;
      if (!pe)     nact = nvis;
      else if (up) nact = m_vis;
    end
    m_vis = nvis;
    m_act = nact;
    e.rd  = nvis;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares after each edge
  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (rd_data !== e.rd || cmp_out !== e.cmp) begin
        errors++;
        $display("FAIL %s: rd_data=%h cmp_out=%b expected rd_data=%h cmp_out=%b",
                 e.tag, rd_data, cmp_out, e.rd, e.cmp);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (rd_data !== '0 || cmp_out !== 1'b0) begin
      errors++;
      $display("FAIL R1: rd_data=%h cmp_out=%b expected 0000 0", rd_data, cmp_out);
    end
    //   md pe we wd       up cp count
    step(0, 1, 0, 16'h0000, 0, 0, 16'h0000, "R1 active zero after reset");
    step(0, 0, 1, 16'h1234, 0, 0, 16'h0005, "R2 write lands");
    step(0, 0, 0, 16'h0000, 0, 0, 16'h1234, "R3 direct load matches");
    step(0, 0, 0, 16'h0000, 0, 0, 16'h1235, "R7 no match off by one");
    step(0, 1, 1, 16'h00AA, 0, 0, 16'h1234, "R4 active keeps old value");
    step(0, 1, 0, 16'h0000, 0, 0, 16'h00AA, "R4 preload not compared");
    step(0, 1, 0, 16'h0000, 1, 0, 16'h0000, "R5 update strobe");
    step(0, 1, 0, 16'h0000, 0, 0, 16'h00AA, "R5 transferred value matches");
    step(0, 1, 1, 16'h0BEE, 1, 0, 16'h0000, "R6 write with update");
    step(0, 1, 0, 16'h0000, 0, 0, 16'h00AA, "R6 active got old preload");
    step(0, 1, 0, 16'h0000, 0, 0, 16'h0BEE, "R6 new write still pending");
    step(1, 1, 0, 16'h0000, 0, 0, 16'h00AA, "R11 no compare in input mode / R10");
    step(1, 1, 0, 16'h0000, 0, 1, 16'h4321, "R8 capture");
    step(1, 1, 1, 16'hFFFF, 0, 0, 16'h0000, "R9 write ignored");
    step(1, 0, 1, 16'h1111, 0, 1, 16'h7777, "R9 capture beats write");
    step(0, 1, 0, 16'h0000, 0, 0, 16'h00AA, "R10 active kept across modes");
    step(0, 0, 0, 16'h0000, 0, 0, 16'h0000, "R3 active follows visible");
    step(0, 0, 0, 16'h0000, 0, 0, 16'h7777, "R3 follow matches");
    step(0, 0, 1, 16'hFFFF, 0, 0, 16'hFFFF, "R7 compare uses pre-edge active");
    step(0, 0, 0, 16'h0000, 0, 0, 16'hFFFF, "R7 all-ones match");
    step(0, 0, 0, 16'h0000, 0, 0, 16'h0000, "R7 match drops");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule